// File: doc/BRIEF.md
# ATM cell receive filter

This block sits behind a byte-aligned receiver and decides which 53-byte ATM cells reach a downstream cell FIFO. Two header-check machines work on every cell header. A delineator locks onto cell boundaries and reports when that lock is lost. A validator accepts or rejects each cell by its header check code and can repair a single-bit header error. Two configuration bits switch either machine off, which gives four forwarding modes. A third bit enables the single-bit repair, and that repair works whatever the two mode bits say.

Every forwarded cell is held in a two-bank cell store until its last byte has arrived. It is then written out as one burst of 53 bytes, so a rejected cell never puts a partial cell on the output. The mode bits are `{cfg_no_delin, cfg_no_check}`: 00 is normal, 01 ignores header errors, 10 uses fixed 53-byte framing from reset, and 11 passes raw 53-byte blocks.

Top module: `atm_cell_rx_filter`

## Requirements
- R1: The header check byte is the CRC-8 (polynomial x^8+x^2+x+1, zero preset, most significant bit of header byte 1 first) of header bytes 1 to 4, XORed with 0x55 and compared with header byte 5. In normal mode (00) a cell is forwarded only when it was delineated and its check byte is valid. No output byte appears in the first cycle after reset.
- R2: While hunting, the delineator tests every byte position, and the first valid header moves it to presync. Six consecutive valid headers, counting the one found while hunting, move it to sync. The cell whose header completes the sixth is the first one eligible. `delin_loss` is high in hunt and presync, which includes the time right after reset, and low in sync.
- R3: In sync, the seventh consecutive invalid header sends the delineator back to hunt and raises `delin_loss`, and that cell is not forwarded. Fewer than seven invalid headers followed by a valid one leave it in sync.
- R4: In ignore-header-error mode (01), every cell delineated in sync is forwarded, including cells with errored headers. With repair off, its bytes are passed exactly as received.
- R5: In ignore-header-error mode, no cell is forwarded while `delin_loss` is high.
- R6: In forced-framing mode (10), each group of 53 bytes counted from the first byte after reset is treated as a cell and forwarded only if its header is valid or was repaired. `delin_loss` stays low.
- R7: In raw mode (11), every 53-byte group is forwarded unaltered whatever its header, as long as repair is off. `delin_loss` stays low.
- R8: With `cfg_fix_en` high, a single-bit header error seen in the repair state is corrected, and the cell is forwarded with the repaired header. With `cfg_fix_en` low, errored cells are dropped in the modes that check headers (00, 10).
- R9: Repair is independent of the check setting. In raw mode with `cfg_fix_en` high, a single-bit header error is corrected in the output bytes.
- R10: Any header with an error puts the validator in its detection state. There, a further single-bit error is not repaired and the cell is dropped. An error-free header returns the validator to the repair state.
- R11: A forwarded cell leaves as 53 bytes on consecutive cycles, with `out_sop` on the first byte. Output starts only after the cell's last byte has been received. Dropped cells produce no output bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_delin | input | 1 | Mode bit: disable delineation (fixed 53-byte framing) |
| cfg_no_check | input | 1 | Mode bit: disable the header-validity filter |
| cfg_fix_en | input | 1 | Enable single-bit header repair |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Output byte strobe toward the cell FIFO |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a forwarded cell |
| delin_loss | output | 1 | Loss of cell delineation, held low in modes 10 and 11 |

## Verification
The assertions assume that the three configuration bits change only while `rst` is high. They also assume that at most one byte arrives per cycle, so a full cell always takes at least as long to receive as the previous one takes to drain. The relock-span property further relies on the fact that a new lock cannot occur sooner than five cell periods plus one byte after loss is declared. The stimulus keeps within these bounds: every scenario starts with a reset carrying its mode, bytes are fed one per cycle, and each scenario ends with an idle stretch long enough to drain the last stored cell.

// File: rtl/atmrx_pkg.sv
package atmrx_pkg;

    localparam int HDR_LEN   = 5;
    localparam int HDR_BITS  = 8 * HDR_LEN;
    localparam logic [7:0] HEC_COSET = 8'h55;
    localparam logic [7:0] HEC_POLY  = 8'h07;

    typedef enum logic [1:0] {DL_HUNT, DL_PRESYNC, DL_SYNC} dl_state_e;
    typedef enum logic {CV_REPAIR, CV_DETECT} cv_state_e;

    typedef struct packed {
        logic [31:0] body;
        logic [7:0]  hec;
    } hdr_t;

    function automatic logic [7:0] crc8_32(input logic [31:0] d);
        logic [7:0] c;
        logic       fb;
        c = '0;
        for (int i = 31; i >= 0; i--) begin
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [7:0] hdr_syndrome(input hdr_t h);
        return crc8_32(h.body) ^ HEC_COSET ^ h.hec;
    endfunction

    // Mask of the single header bit whose flip explains the syndrome, or zero.
    function automatic logic [HDR_BITS-1:0] single_fix_mask(input logic [7:0] syn);
        logic [HDR_BITS-1:0] m;
        logic [HDR_BITS-1:0] e;
        m = '0;
        for (int i = 0; i < HDR_BITS; i++) begin
            e = HDR_BITS'(1) << i;
            if (syn != 8'h00 && ((crc8_32(e[HDR_BITS-1:8]) ^ e[7:0]) == syn))
                m = e;
        end
        return m;
    endfunction

endpackage

// File: rtl/atmrx_delin.sv
module atmrx_delin
    import atmrx_pkg::*;
#(
    parameter int CELL_LEN   = 53,
    parameter int SYNC_DELTA = 6,
    parameter int LOSS_ALPHA = 7,
    localparam int CW = $clog2(CELL_LEN),
    localparam int RW = $clog2(SYNC_DELTA + LOSS_ALPHA + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          no_delin,
    input  logic          stb,
    input  logic [7:0]    din,
    output logic          hdr_evt,
    output hdr_t          hdr,
    output logic          eligible,
    output logic          pay_wr,
    output logic [CW-1:0] pay_idx,
    output logic          cell_end,
    output logic          loss
);
    localparam logic [CW-1:0] IDX_LAST  = CW'(CELL_LEN - 1);
    localparam logic [CW-1:0] IDX_HLAST = CW'(HDR_LEN - 1);
    localparam logic [CW-1:0] IDX_PAY   = CW'(HDR_LEN);
    localparam logic [2:0]    FILL_MAX  = 3'(HDR_LEN - 1);

    dl_state_e           st, st_nx;
    logic [RW-1:0]       run, run_nx;
    logic [CW-1:0]       cnt, cnt_nx;
    logic [2:0]          fill;
    logic [HDR_BITS-1:0] win, win_nx;
    logic                match, in_frame, hdr_pos;

    assign win_nx  = {win[HDR_BITS-9:0], din};
    assign hdr     = hdr_t'(win_nx);
    assign match   = (hdr_syndrome(hdr_t'(win_nx)) == 8'h00);
    assign hdr_pos = stb && (cnt == IDX_HLAST);

    always_comb begin
        st_nx   = st;
        run_nx  = run;
        hdr_evt = 1'b0;
        cnt_nx  = cnt;
        if (stb)
            cnt_nx = (cnt == IDX_LAST) ? '0 : cnt + 1'b1;
        if (no_delin) begin
            hdr_evt = hdr_pos;
        end else begin
            unique case (st)
                DL_HUNT: if (stb && fill == FILL_MAX && match) begin
                    hdr_evt = 1'b1;
                    st_nx   = DL_PRESYNC;
                    run_nx  = RW'(1);
                    cnt_nx  = IDX_PAY;
                end
                DL_PRESYNC: if (hdr_pos) begin
                    hdr_evt = 1'b1;
                    if (!match) begin
                        st_nx  = DL_HUNT;
                        run_nx = '0;
                    end else if (run == RW'(SYNC_DELTA - 1)) begin
                        st_nx  = DL_SYNC;
                        run_nx = '0;
                    end else begin
                        run_nx = run + 1'b1;
                    end
                end
                DL_SYNC: if (hdr_pos) begin
                    hdr_evt = 1'b1;
                    if (match) begin
                        run_nx = '0;
                    end else if (run == RW'(LOSS_ALPHA - 1)) begin
                        st_nx  = DL_HUNT;
                        run_nx = '0;
                    end else begin
                        run_nx = run + 1'b1;
                    end
                end
                default: st_nx = DL_HUNT;
            endcase
        end
    end

    assign eligible = (st_nx == DL_SYNC);
    assign in_frame = no_delin || (st != DL_HUNT);
    assign pay_wr   = stb && in_frame && (cnt >= IDX_PAY);
    assign pay_idx  = cnt;
    assign cell_end = pay_wr && (cnt == IDX_LAST);
    assign loss     = !no_delin && (st != DL_SYNC);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= DL_HUNT;
            run  <= '0;
            cnt  <= '0;
            fill <= '0;
            win  <= '0;
        end else begin
            st  <= st_nx;
            run <= run_nx;
            cnt <= cnt_nx;
            if (stb) begin
                win <= win_nx;
                if (fill != FILL_MAX)
                    fill <= fill + 1'b1;
            end
        end
    end
endmodule

// File: rtl/atmrx_cval.sv
module atmrx_cval
    import atmrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                evt,
    input  hdr_t                hdr_in,
    input  logic                no_delin,
    input  logic                no_check,
    input  logic                fix_en,
    input  logic                eligible,
    output logic [HDR_BITS-1:0] hdr_out,
    output logic                keep
);
    cv_state_e           cv;
    logic [7:0]          syn;
    logic [HDR_BITS-1:0] mask;
    logic                do_fix, pass;

    assign syn     = hdr_syndrome(hdr_in);
    assign mask    = single_fix_mask(syn);
    assign do_fix  = fix_en && (cv == CV_REPAIR) && (mask != '0);
    assign hdr_out = hdr_in ^ (do_fix ? mask : '0);
    assign pass    = (syn == 8'h00) || do_fix;

    always_comb begin
        unique case ({no_delin, no_check})
            2'b00:   keep = eligible && pass;
            2'b01:   keep = eligible;
            2'b10:   keep = pass;
            default: keep = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cv <= CV_REPAIR;
        else if (evt)
            cv <= (syn == 8'h00) ? CV_REPAIR : CV_DETECT;
    end
endmodule

// File: rtl/atmrx_cellbuf.sv
module atmrx_cellbuf
    import atmrx_pkg::*;
#(
    parameter int CELL_LEN = 53,
    localparam int CW = $clog2(CELL_LEN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hdr_evt,
    input  logic [HDR_BITS-1:0] hdr_data,
    input  logic                keep,
    input  logic                pay_wr,
    input  logic [CW-1:0]       pay_idx,
    input  logic [7:0]          din,
    input  logic                cell_end,
    output logic                out_valid,
    output logic [7:0]          out_data,
    output logic                out_sop
);
    localparam logic [CW-1:0] IDX_LAST = CW'(CELL_LEN - 1);

    logic [7:0]    mem [2][CELL_LEN];
    logic          wbank, rbank, keep_q, rd_active;
    logic [CW-1:0] rd_idx;

    always_ff @(posedge clk) begin
        if (hdr_evt)
            for (int i = 0; i < HDR_LEN; i++)
                mem[wbank][i] <= hdr_data[8*(HDR_LEN-1-i) +: 8];
        if (pay_wr)
            mem[wbank][pay_idx] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbank     <= 1'b0;
            rbank     <= 1'b0;
            keep_q    <= 1'b0;
            rd_active <= 1'b0;
            rd_idx    <= '0;
        end else begin
            if (hdr_evt)
                keep_q <= keep;
            if (rd_active) begin
                if (rd_idx == IDX_LAST)
                    rd_active <= 1'b0;
                else
                    rd_idx <= rd_idx + 1'b1;
            end
            if (cell_end && keep_q) begin
                rd_active <= 1'b1;
                rd_idx    <= '0;
                rbank     <= wbank;
                wbank     <= ~wbank;
            end
        end
    end

    assign out_valid = rd_active;
    assign out_data  = mem[rbank][rd_idx];
    assign out_sop   = rd_active && (rd_idx == '0);
endmodule

// File: rtl/atm_cell_rx_filter.sv
module atm_cell_rx_filter
    import atmrx_pkg::*;
#(
    parameter int CELL_LEN   = 53,
    parameter int SYNC_DELTA = 6,
    parameter int LOSS_ALPHA = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_no_delin,
    input  logic       cfg_no_check,
    input  logic       cfg_fix_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sop,
    output logic       delin_loss
);
    localparam int CW = $clog2(CELL_LEN);

    logic                hdr_evt, eligible, pay_wr, cell_end, keep;
    hdr_t                hdr_raw;
    logic [HDR_BITS-1:0] hdr_fixed;
    logic [CW-1:0]       pay_idx;

    atmrx_delin #(
        .CELL_LEN  (CELL_LEN),
        .SYNC_DELTA(SYNC_DELTA),
        .LOSS_ALPHA(LOSS_ALPHA)
    ) u_delin (
        .clk     (clk),
        .rst     (rst),
        .no_delin(cfg_no_delin),
        .stb     (in_valid),
        .din     (in_data),
        .hdr_evt (hdr_evt),
        .hdr     (hdr_raw),
        .eligible(eligible),
        .pay_wr  (pay_wr),
        .pay_idx (pay_idx),
        .cell_end(cell_end),
        .loss    (delin_loss)
    );

    atmrx_cval u_cval (
        .clk     (clk),
        .rst     (rst),
        .evt     (hdr_evt),
        .hdr_in  (hdr_raw),
        .no_delin(cfg_no_delin),
        .no_check(cfg_no_check),
        .fix_en  (cfg_fix_en),
        .eligible(eligible),
        .hdr_out (hdr_fixed),
        .keep    (keep)
    );

    atmrx_cellbuf #(.CELL_LEN(CELL_LEN)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .hdr_evt  (hdr_evt),
        .hdr_data (hdr_fixed),
        .keep     (keep),
        .pay_wr   (pay_wr),
        .pay_idx  (pay_idx),
        .din      (in_data),
        .cell_end (cell_end),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_sop  (out_sop)
    );
endmodule

// File: rtl/atmrx_checker.sv
module atmrx_checker #(
    parameter int CELL_LEN   = 53,
    parameter int SYNC_DELTA = 6
) (
    input logic clk,
    input logic rst,
    input logic cfg_no_delin,
    input logic in_valid,
    input logic out_valid,
    input logic out_sop,
    input logic delin_loss
);
    localparam int BW = $clog2(CELL_LEN + 2) + 1;
    localparam logic [BW-1:0] BCELL = BW'(CELL_LEN);
    localparam logic [15:0] MIN_RELOCK = 16'((SYNC_DELTA - 1) * CELL_LEN + 1);

    logic [BW-1:0] bcnt;
    logic [15:0]   lock_bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt       <= '0;
            lock_bytes <= '0;
        end else begin
            if (out_valid)
                bcnt <= out_sop ? BW'(1) : ((bcnt == '1) ? bcnt : bcnt + 1'b1);
            if (!delin_loss)
                lock_bytes <= '0;
            else if (in_valid && lock_bytes != 16'hFFFF)
                lock_bytes <= lock_bytes + 1'b1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    p_loss_at_start_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !cfg_no_delin) |-> delin_loss);

    p_relock_span_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(delin_loss) && !$past(rst)) |-> (lock_bytes >= MIN_RELOCK));

    p_mid_cell_r11: assert property (@(posedge clk) disable iff (rst)
        (bcnt != '0 && bcnt < BCELL) |-> (out_valid && !out_sop));

    p_sop_start_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (bcnt == '0 || bcnt >= BCELL)) |-> out_sop);

    p_sop_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);
endmodule

bind atm_cell_rx_filter atmrx_checker #(
    .CELL_LEN  (CELL_LEN),
    .SYNC_DELTA(SYNC_DELTA)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_no_delin(cfg_no_delin),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_sop     (out_sop),
    .delin_loss  (delin_loss)
);

// File: tb/atm_cell_rx_filter_bench.sv
module atm_cell_rx_filter_bench;
    localparam int PERIOD = 10;
    localparam int CELL   = 53;
    localparam logic [39:0] ERR1 = 40'h00_0010_0000;   // one bit in header byte 3
    localparam logic [39:0] ERR2 = 40'h03_0000_0000;   // two bits in header byte 1

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_no_delin = 1'b0, cfg_no_check = 1'b0, cfg_fix_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_sop, delin_loss;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] cap [0:1023];
    int cap_n = 0, cap_cells = 0, sop_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    atm_cell_rx_filter u_atm_cell_rx_filter (
        .clk(clk), .rst(rst), .cfg_no_delin(cfg_no_delin), .cfg_no_check(cfg_no_check),
        .cfg_fix_en(cfg_fix_en), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .delin_loss(delin_loss)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && cap_n < 1024) begin
            if (out_sop) begin
                if (cap_n % CELL != 0) sop_bad++;
                cap_cells++;
            end
            cap[cap_n] = out_data;
            cap_n++;
        end
    end

    function automatic logic [7:0] tb_hec(input logic [31:0] b);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 31; i >= 0; i--)
            r = {r[6:0], 1'b0} ^ ((r[7] ^ b[i]) ? 8'h07 : 8'h00);
        return r ^ 8'h55;
    endfunction

    function automatic logic [31:0] hbody(input int n);
        return {8'h0A, 8'h5C, 8'(n), 8'h30};
    endfunction

    function automatic logic [7:0] cell_byte(input int n, input logic [39:0] err, input int j);
        logic [39:0] h;
        h = {hbody(n), tb_hec(hbody(n))} ^ err;
        if (j < 5) return h[8*(4-j) +: 8];
        return 8'(n * 7 + 1) + 8'(j);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic nd, input logic nc, input logic fx);
        rst = 1'b1; in_valid = 1'b0;
        cfg_no_delin = nd; cfg_no_check = nc; cfg_fix_en = fx;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cap_n = 0; cap_cells = 0; sop_bad = 0;
    endtask

    task automatic send_cell(input int n, input logic [39:0] err);
        for (int j = 0; j < CELL; j++) begin
            in_valid = 1'b1;
            in_data  = cell_byte(n, err, j);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (70) @(negedge clk);
    endtask

    // Compare captured cell k with cell n carrying header error err.
    task automatic check_cell(input string tag, input int k, input int n, input logic [39:0] err);
        int bad_j;
        int act;
        int exp;
        bad_j = -1; act = 0; exp = 0;
        for (int j = CELL - 1; j >= 0; j--)
            if (k * CELL + j >= cap_n || cap[k*CELL + j] !== cell_byte(n, err, j)) begin
                bad_j = j;
                act = (k * CELL + j < cap_n) ? int'(cap[k*CELL + j]) : -1;
                exp = int'(cell_byte(n, err, j));
            end
        chk(tag, act, exp);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R2 loss high after reset", int'(delin_loss), 1);
        chk("R1 no output after reset", int'(out_valid), 0);
    endtask

    task automatic t_normal();
        do_reset(1'b0, 1'b0, 1'b0);
        for (int n = 0; n < 10; n++) send_cell(n, '0);
        drain();
        chk("R2 cells forwarded once sync reached on sixth header", cap_cells, 5);
        chk("R2 loss low in sync", int'(delin_loss), 0);
        check_cell("R1 first forwarded cell content", 0, 5, '0);
        chk("R11 sop aligned to 53-byte bursts", sop_bad, 0);
        chk("R11 byte count is whole cells", cap_n, cap_cells * CELL);
        for (int n = 10; n < 16; n++) send_cell(n, ERR2);
        send_cell(20, '0);
        drain();
        chk("R3 six bad then good keeps sync, bad dropped", cap_cells, 6);
        chk("R3 loss stays low", int'(delin_loss), 0);
        check_cell("R1 clean cell after errored run", 5, 20, '0);
        for (int n = 30; n < 37; n++) send_cell(n, ERR2);
        drain();
        chk("R3 seventh bad header declares loss", int'(delin_loss), 1);
        chk("R8 errored cells dropped with repair off", cap_cells, 6);
    endtask

    task automatic t_ignore();
        do_reset(1'b0, 1'b1, 1'b0);
        for (int n = 0; n < 6; n++) send_cell(n, '0);
        for (int n = 6; n < 12; n++) send_cell(n, ERR2);
        drain();
        chk("R4 errored cells forwarded in sync", cap_cells, 7);
        check_cell("R4 errored cell passed as received", 1, 6, ERR2);
        send_cell(12, ERR2);
        drain();
        chk("R3 seventh bad in ignore mode raises loss", int'(delin_loss), 1);
        chk("R3 seventh bad cell not forwarded", cap_cells, 7);
        for (int n = 13; n < 16; n++) send_cell(n, '0);
        drain();
        chk("R5 nothing forwarded during loss", cap_cells, 7);
    endtask

    task automatic t_forced();
        do_reset(1'b1, 1'b0, 1'b0);
        send_cell(0, '0);
        send_cell(1, ERR2);
        send_cell(2, '0);
        send_cell(3, ERR1);
        send_cell(4, '0);
        drain();
        chk("R6 only valid groups forwarded", cap_cells, 3);
        check_cell("R6 second forwarded group", 1, 2, '0);
        check_cell("R6 third forwarded group", 2, 4, '0);
        chk("R6 loss held low", int'(delin_loss), 0);
    endtask

    task automatic t_repair();
        do_reset(1'b0, 1'b0, 1'b1);
        for (int n = 0; n < 6; n++) send_cell(n, '0);
        send_cell(10, ERR1);
        send_cell(11, ERR1);
        send_cell(12, '0);
        send_cell(13, ERR1);
        drain();
        chk("R10 count with detection-state drop", cap_cells, 4);
        check_cell("R8 single-bit header repaired", 1, 10, '0);
        check_cell("R10 clean cell after detection drop", 2, 12, '0);
        check_cell("R10 repair restored after clean header", 3, 13, '0);
    endtask

    task automatic t_raw();
        do_reset(1'b1, 1'b1, 1'b0);
        send_cell(0, ERR2);
        send_cell(1, '0);
        drain();
        chk("R7 every block forwarded", cap_cells, 2);
        check_cell("R7 errored block unaltered", 0, 0, ERR2);
        chk("R7 loss held low", int'(delin_loss), 0);
        do_reset(1'b1, 1'b1, 1'b1);
        send_cell(2, ERR1);
        drain();
        chk("R9 raw block forwarded", cap_cells, 1);
        check_cell("R9 repair active with check disabled", 0, 2, '0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_normal();
        t_ignore();
        t_forced();
        t_repair();
        t_raw();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule